// File: doc/BRIEF.md
# Event Status, Interrupt and DMA Request Unit

This unit records the events raised by a serial bus controller's FIFO and transfer logic, and turns them into one interrupt line and two DMA request lines. Each event source raises a one-cycle set pulse on its own bit of a 16-bit status word. The bit then stays set until it is cleared. Software clears bits by writing ones to the status word. The FIFO logic clears the data-ready bits directly through a hardware clear input. The bus-busy indication is never stored: it comes in live and appears only in the status read value.

Software programs an interrupt enable mask, a wakeup enable mask and a DMA configuration word through a simple register port. Register reads are combinational and are valid in the cycle that the select is presented. An optional legacy vector register reports the lowest-numbered pending enabled event and acknowledges it in the same access. A diagnostic write can force a group of status bits on, so that the interrupt path can be exercised.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, the status, interrupt enable, wakeup enable and DMA configuration are all zero, and irq_o, rx_dma_req_o and tx_dma_req_o are low.
- R2: A high bit b of set_i sets status bit b, and the bit stays set until it is cleared. The bit positions are: 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 7 access error, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain, 15 single byte.
- R3: Status bit 12 is not stored. A status read returns bit 12 equal to bus_busy_i in that same cycle.
- R4: A write to the status register clears the bits that are one in both the written value and 0x63E7. Bits 3, 4, 10, 11 and 15 are not affected by software writes and are cleared only by the matching bits of hw_clr_i.
- R5: When a set pulse and any clear (software write, hardware clear or vector acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R6: irq_o is high exactly when the bitwise AND of the status and the interrupt enable is nonzero.
- R7: The interrupt enable register keeps only the bits in 0x63FF. The wakeup enable register keeps only the bits in 0x636F.
- R8: rx_dma_req_o equals DMA configuration bit 15 AND status bit 3. tx_dma_req_o equals DMA configuration bit 7 AND status bit 4. The DMA configuration register stores only bits 15 and 7.
- R9: A DMA configuration write with bit 15 set clears interrupt enable bit 3. A write with bit 7 set clears interrupt enable bit 4.
- R10: With VEC_EN=1, a read of the vector register returns, in bits 4:0, the 1-based index of the lowest set bit of status AND enable, or 0 if none is set. At the same clock edge it clears that status bit, and the outputs follow from the new value.
- R11: A write to the test register with bit 11 set forces status bits 0x063F on. The test register reads 0.
- R12: reg_sel_i selects 0 status, 1 interrupt enable, 2 wakeup enable, 3 vector, 4 DMA configuration, 5 test. A write affects only the selected register, and other selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 16 | Event set pulses, one per status bit |
| hw_clr_i | input | 16 | Hardware clear pulses, one per status bit |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (has side effects only on the vector register) |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
Two functions can act on the same status bit in one cycle: an event set pulse, and a clear that comes either from a software write-one or from the vector acknowledge. The bench provokes both collisions. It drives a set pulse on bit 2 in the same cycle as a write-one to bit 2. It also drives a set pulse on bit 1 in the same cycle as a vector read that selects bit 1. In both cases it reads the status back and requires the bit to be set. The vector read is also judged on its returned index, on the status left behind, and on irq_o falling once no enabled event remains.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned ST_W     = 16;
  localparam int unsigned VEC_W    = $clog2(ST_W + 1);
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned BUSY_BIT = 12;
  localparam int unsigned RXRDY_BIT = 3;
  localparam int unsigned TXRDY_BIT = 4;
  localparam int unsigned RXDMA_BIT = 15;
  localparam int unsigned TXDMA_BIT = 7;
  localparam int unsigned FORCE_BIT = 11;

  localparam logic [ST_W-1:0] STORE_MASK = ~(ST_W'(1) << BUSY_BIT);
  localparam logic [ST_W-1:0] SWCLR_MASK = 16'h63E7;
  localparam logic [ST_W-1:0] IE_MASK    = 16'h63FF;
  localparam logic [ST_W-1:0] WAKE_MASK  = 16'h636F;
  localparam logic [ST_W-1:0] FORCE_VAL  = 16'h063F;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 3'd0,
    SEL_IE   = 3'd1,
    SEL_WAKE = 3'd2,
    SEL_VEC  = 3'd3,
    SEL_DMA  = 3'd4,
    SEL_TEST = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] hw_clr_i,
  input  logic [ST_W-1:0] sw_clr_i,   // raw write-one data
  input  logic [ST_W-1:0] vec_clr_i,
  input  logic            force_i,
  output logic [ST_W-1:0] stat_o
);
  logic [ST_W-1:0] stat_q, stat_d, clr_all, set_all;

  always_comb begin
    clr_all = hw_clr_i | (sw_clr_i & SWCLR_MASK) | vec_clr_i;
    set_all = set_i | (force_i ? FORCE_VAL : '0);
    // set has priority over any clear
    stat_d  = ((stat_q & ~clr_all) | set_all) & STORE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  localparam logic [ST_W-1:0] HW_ONLY = STORE_MASK & ~SWCLR_MASK;

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i & STORE_MASK)) == $past(set_i & STORE_MASK)));

  p_hw_only_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i != '0 && hw_clr_i == '0 && vec_clr_i == '0)
      |=> ((stat_q & $past(stat_q & HW_ONLY)) == $past(stat_q & HW_ONLY)));

  p_vec_ack_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_clr_i != '0 && (vec_clr_i & set_i) == '0 && !force_i)
      |=> ((stat_q & $past(vec_clr_i)) == '0));
endmodule

// File: rtl/evt_mask_regs.sv
module evt_mask_regs
  import evt_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ie_we_i,
  input  logic            wake_we_i,
  input  logic            dma_we_i,
  input  logic [ST_W-1:0] wdata_i,
  output logic [ST_W-1:0] ie_o,
  output logic [ST_W-1:0] wake_o,
  output logic            rx_dma_en_o,
  output logic            tx_dma_en_o
);
  logic [ST_W-1:0] ie_q, wake_q;
  logic            rx_en_q, tx_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q    <= '0;
      wake_q  <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      if (ie_we_i)   ie_q   <= wdata_i & IE_MASK;
      if (wake_we_i) wake_q <= wdata_i & WAKE_MASK;
      if (dma_we_i) begin
        rx_en_q <= wdata_i[RXDMA_BIT];
        tx_en_q <= wdata_i[TXDMA_BIT];
        // DMA takes over a direction: drop its ready interrupt
        if (wdata_i[RXDMA_BIT]) ie_q[RXRDY_BIT] <= 1'b0;
        if (wdata_i[TXDMA_BIT]) ie_q[TXRDY_BIT] <= 1'b0;
      end
    end
  end

  assign ie_o        = ie_q;
  assign wake_o      = wake_q;
  assign rx_dma_en_o = rx_en_q;
  assign tx_dma_en_o = tx_en_q;

  p_rx_dma_masks_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_we_i && wdata_i[RXDMA_BIT]) |=> !ie_q[RXRDY_BIT]);

  p_tx_dma_masks_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_we_i && wdata_i[TXDMA_BIT]) |=> !ie_q[TXRDY_BIT]);

  p_ie_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_we_i |=> ((ie_q & ~IE_MASK) == '0));
endmodule

// File: rtl/evt_lowest_enc.sv
module evt_lowest_enc
  import evt_irq_pkg::*;
#(
  parameter int unsigned W  = ST_W,
  parameter int unsigned IW = $clog2(W + 1)
) (
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] idx_o,     // 1-based, 0 when none
  output logic [W-1:0]  onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i + 1);
    end
  end

  assign onehot_o = req_i & (~req_i + W'(1));

  always_comb begin
    assert ($onehot0(onehot_o)) else $error("p_onehot_ack_r10");
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter bit VEC_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] set_i,
  input  logic [15:0] hw_clr_i,
  input  logic        bus_busy_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  output logic        rx_dma_req_o,
  output logic        tx_dma_req_o
);
  logic [ST_W-1:0]  stat, ie, wake, pend, ack_oh, vec_clr, sw_clr;
  logic [VEC_W-1:0] vec_idx;
  logic             rx_en, tx_en, force_on;
  reg_sel_e         sel;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign sw_clr   = (reg_we_i && sel == SEL_STAT) ? reg_wdata_i : '0;
  assign force_on = reg_we_i && sel == SEL_TEST && reg_wdata_i[FORCE_BIT];
  assign pend     = stat & ie;

  evt_status_reg u_stat (
    .clk_i, .rst_ni,
    .set_i, .hw_clr_i,
    .sw_clr_i (sw_clr),
    .vec_clr_i(vec_clr),
    .force_i  (force_on),
    .stat_o   (stat)
  );

  evt_mask_regs u_masks (
    .clk_i, .rst_ni,
    .ie_we_i    (reg_we_i && sel == SEL_IE),
    .wake_we_i  (reg_we_i && sel == SEL_WAKE),
    .dma_we_i   (reg_we_i && sel == SEL_DMA),
    .wdata_i    (reg_wdata_i),
    .ie_o       (ie),
    .wake_o     (wake),
    .rx_dma_en_o(rx_en),
    .tx_dma_en_o(tx_en)
  );

  generate
    if (VEC_EN) begin : g_vec
      evt_lowest_enc #(.W(ST_W), .IW(VEC_W)) u_enc (
        .req_i   (pend),
        .idx_o   (vec_idx),
        .onehot_o(ack_oh)
      );
      assign vec_clr = (reg_re_i && sel == SEL_VEC) ? ack_oh : '0;
    end else begin : g_no_vec
      assign vec_idx = '0;
      assign ack_oh  = '0;
      assign vec_clr = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_STAT: reg_rdata_o = stat | (ST_W'(bus_busy_i) << BUSY_BIT);
      SEL_IE:   reg_rdata_o = ie;
      SEL_WAKE: reg_rdata_o = wake;
      SEL_VEC:  reg_rdata_o = ST_W'(vec_idx);
      SEL_DMA:  reg_rdata_o = (ST_W'(rx_en) << RXDMA_BIT) | (ST_W'(tx_en) << TXDMA_BIT);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o        = |pend;
  assign rx_dma_req_o = rx_en & stat[RXRDY_BIT];
  assign tx_dma_req_o = tx_en & stat[TXRDY_BIT];

  p_irq_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie != '0 && stat != '0));

  p_rx_req_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> rx_en);

  p_tx_req_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> tx_en);

  p_force_sets_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_on |=> ((stat & FORCE_VAL) == FORCE_VAL));
endmodule

// File: tb/evt_irq_unit_bench.sv
`timescale 1ns/1ps
module evt_irq_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] set_i, hw_clr_i, reg_wdata_i, reg_rdata_o;
  logic        bus_busy_i, reg_we_i, reg_re_i;
  logic [2:0]  reg_sel_i;
  logic        irq_o, rx_dma_req_o, tx_dma_req_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // scoreboard queues: kind 0 rdata, 1 irq, 2 rx req, 3 tx req
  int          kq[$];
  logic [15:0] eq[$];
  string       tq[$];

  always #2 clk_i = ~clk_i;

  evt_irq_unit u_evt_irq_unit (.*);

  task automatic idle();
    reg_we_i = 1'b0; reg_re_i = 1'b0; reg_sel_i = 3'd0;
    reg_wdata_i = '0; set_i = '0; hw_clr_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1; idle();
  endtask

  task automatic push(int k, logic [15:0] e, string t);
    kq.push_back(k); eq.push_back(e); tq.push_back(t);
  endtask

  task automatic wr(logic [2:0] s, logic [15:0] d);
    reg_we_i = 1'b1; reg_sel_i = s; reg_wdata_i = d; tick();
  endtask

  task automatic rd(logic [2:0] s, logic [15:0] e, string t);
    reg_re_i = 1'b1; reg_sel_i = s; push(0, e, t); tick();
  endtask

  task automatic outs(logic irq, logic rx, logic tx, string t);
    push(1, 16'(irq), t); push(2, 16'(rx), t); push(3, 16'(tx), t); tick();
  endtask

  task automatic pulse(logic [15:0] s, logic [15:0] h);
    set_i = s; hw_clr_i = h; tick();
  endtask

  // monitor: compares at the falling edge, inputs change after the rising edge
  always @(negedge clk_i) begin
    while (kq.size() > 0) begin
      int k; logic [15:0] e, a; string t;
      k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
      case (k)
        0: a = reg_rdata_o;
        1: a = 16'(irq_o);
        2: a = 16'(rx_dma_req_o);
        default: a = 16'(tx_dma_req_o);
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); bus_busy_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1
    rd(3'd0, 16'h0000, "R1 status");
    rd(3'd1, 16'h0000, "R1 ie");
    rd(3'd4, 16'h0000, "R1 dma cfg");
    outs(1'b0, 1'b0, 1'b0, "R1 outputs");
    // R3
    bus_busy_i = 1'b1;
    rd(3'd0, 16'h1000, "R3 busy live");
    bus_busy_i = 1'b0;
    rd(3'd0, 16'h0000, "R3 busy dropped");
    // R2 / R6
    pulse(16'h0002, 16'h0);
    rd(3'd0, 16'h0002, "R2 nack set");
    outs(1'b0, 1'b0, 1'b0, "R6 masked");
    wr(3'd1, 16'h0002);
    outs(1'b1, 1'b0, 1'b0, "R6 enabled");
    // R4
    wr(3'd0, 16'h0002);
    rd(3'd0, 16'h0000, "R4 w1c");
    outs(1'b0, 1'b0, 1'b0, "R6 after clear");
    pulse(16'h8C18, 16'h0);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h8C18, "R4 hw-only bits kept");
    pulse(16'h0, 16'h8C18);
    rd(3'd0, 16'h0000, "R4 hw clear");
    // R5 set vs software clear
    reg_we_i = 1'b1; reg_sel_i = 3'd0; reg_wdata_i = 16'h0004; set_i = 16'h0004; tick();
    rd(3'd0, 16'h0004, "R5 set beats w1c");
    wr(3'd0, 16'h0004);
    // R7 / R12
    wr(3'd1, 16'hFFFF);
    rd(3'd1, 16'h63FF, "R7 ie mask");
    wr(3'd2, 16'hFFFF);
    rd(3'd2, 16'h636F, "R7 wake mask");
    rd(3'd1, 16'h63FF, "R12 ie untouched by wake write");
    rd(3'd6, 16'h0000, "R12 unused select");
    // R9
    wr(3'd4, 16'h8000);
    rd(3'd1, 16'h63F7, "R9 rx masks ie3");
    rd(3'd4, 16'h8000, "R8 cfg readback");
    wr(3'd4, 16'hFFFF);
    rd(3'd1, 16'h63E7, "R9 tx masks ie4");
    rd(3'd4, 16'h8080, "R8 cfg stores two bits");
    // R8
    wr(3'd4, 16'h0080);
    pulse(16'h0018, 16'h0);
    outs(1'b0, 1'b0, 1'b1, "R8 tx only");
    wr(3'd4, 16'h8080);
    outs(1'b0, 1'b1, 1'b1, "R8 both");
    pulse(16'h0, 16'h0018);
    outs(1'b0, 1'b0, 1'b0, "R8 ready cleared");
    wr(3'd4, 16'h0000);
    // R10 vector
    pulse(16'h0026, 16'h0);
    wr(3'd1, 16'h0024);
    outs(1'b1, 1'b0, 1'b0, "R10 irq before");
    rd(3'd3, 16'd3, "R10 first vector");
    rd(3'd0, 16'h0022, "R10 bit2 acked");
    rd(3'd3, 16'd6, "R10 second vector");
    rd(3'd0, 16'h0002, "R10 bit5 acked");
    rd(3'd3, 16'd0, "R10 none pending");
    rd(3'd0, 16'h0002, "R10 disabled bit kept");
    outs(1'b0, 1'b0, 1'b0, "R10 irq re-evaluated");
    // R5 set vs vector acknowledge
    wr(3'd1, 16'h0002);
    reg_re_i = 1'b1; reg_sel_i = 3'd3; set_i = 16'h0002; push(0, 16'd2, "R10 vector under collision"); tick();
    rd(3'd0, 16'h0002, "R5 set beats vector ack");
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0000);
    // R11
    wr(3'd5, 16'h0800);
    rd(3'd0, 16'h063F, "R11 forced bits");
    rd(3'd5, 16'h0000, "R11 test reads zero");
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h0418, "R4 forced hw-only remain");
    pulse(16'h0, 16'h0418);
    rd(3'd0, 16'h0000, "R4 final clear");
    tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule